// File: doc/BRIEF.md
# Disk Read Sector Sequencer

This block performs the read-data command of a cartridge disk controller. On a command write that carries read function code 6 or 7, it takes a disk address word, a negated word count and an 18-bit start address. It decodes the disk address into cylinder, head and sector. It then streams 16-bit words from a disk-image read port into system memory through a request/grant write interface. The image address is a linear byte offset: each cylinder holds two heads, and each head holds a track of sectors.

Data is handled one sector at a time. After each sector, and after a short final sector, the position moves on, rolling over from sector to head and from head to cylinder. When the last word has been accepted, the block drops its busy flag and raises a one-cycle done pulse, which the interrupt logic can use. At that moment the memory address output holds the final bus address, ready to be written back to the address and control/status registers. Function code 7 skips the header check. Header checking is not modelled, so both codes behave the same.

Top module: `dskrd_seq`

## Requirements
- R1: After reset, busy, done and mem_req are 0, mem_addr is 0, the position (pos_cyl, pos_head, pos_sect) is 0 and img_addr is 0.
- R2: A transfer starts only when cmd_valid is high while idle and cmd_func is 3'd6 or 3'd7. Busy rises in the next cycle. Any other function code leaves busy at 0 and memory untouched.
- R3: At the start, pos_sect is loaded from dar[5:0], pos_head from dar[6] and pos_cyl from dar[15:7].
- R4: img_addr equals ((pos_cyl*2 + pos_head)*40 + pos_sect)*256 + 2*(number of words already moved in the current sector).
- R5: The transfer moves exactly 65536 − wcnt words, so wcnt = 0 moves 65536 words.
- R6: mem_addr starts at base_addr and advances by 2 on each granted word. It carries from bit 15 into bits 17:16 and wraps modulo 2^18.
- R7: While busy, mem_req is high, and mem_data equals img_data for the current img_addr. mem_addr and img_addr stay stable until mem_gnt is seen.
- R8: After 128 words of a sector, or after the final word of a transfer, the position advances. A sector of 39 or more wraps to 0 and moves the head on. Head 1 wraps to 0 and increments the cylinder, which wraps from 511 to 0.
- R9: In the cycle after the last grant, done is high for exactly one cycle and busy is 0. mem_addr then holds the address that follows the last word written.
- R10: Command writes while busy are ignored: position, address and count continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_func | input | 3 | Function code of the command |
| dar | input | 16 | Disk address word |
| wcnt | input | 16 | Negated word count |
| base_addr | input | 18 | Start bus address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write grant |
| mem_addr | output | 18 | Memory write address / final bus address |
| mem_data | output | 16 | Memory write data |
| img_addr | output | 24 | Disk image byte offset |
| img_data | input | 16 | Disk image word at img_addr |
| pos_cyl | output | 9 | Current cylinder |
| pos_head | output | 1 | Current head |
| pos_sect | output | 6 | Current sector |

## Verification
The bench targets the rollovers. It drives a transfer from sector 38 across a head change and a transfer from cylinder 511, head 1, sector 39 into cylinder 0. If a design wrapped at the wrong sector or forgot the head step, img_addr would jump to the wrong offset, and that shows at once. A base address just below a 64 KiB boundary, and another just below the 18-bit limit, expose a missing carry into the extension bits. Single-word transfers, a count of zero (65536 words) and irregular grant patterns test whether the design counts words correctly, holds its request while stalled and pulses done once. A command issued mid-transfer checks that a busy sequencer does not reload.

// File: rtl/dskrd_pkg.sv
package dskrd_pkg;
  localparam int DAR_W   = 16;
  localparam int CYL_W   = 9;
  localparam int SECT_W  = 6;
  localparam int FUNC_W  = 3;
  localparam logic [FUNC_W-1:0] FN_READ   = 3'd6;
  localparam logic [FUNC_W-1:0] FN_READNH = 3'd7;

  typedef struct packed {
    logic [CYL_W-1:0]  cyl;
    logic              head;
    logic [SECT_W-1:0] sect;
  } chs_t;
endpackage

// File: rtl/dskrd_pos.sv
module dskrd_pos
  import dskrd_pkg::*;
#(
  parameter int SPT        = 40,
  parameter int SECT_BYTES = 256,
  parameter int OFF_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  chs_t             chs_in,
  input  logic             step,
  input  logic             last,
  output chs_t             pos,
  output logic [OFF_W-1:0] offset
);
  localparam int WPS   = SECT_BYTES / 2;
  localparam int WIS_W = $clog2(WPS);

  chs_t             pos_q, pos_d;
  logic [WIS_W-1:0] wis_q, wis_d;
  logic             adv;

  assign adv = step && ((wis_q == WIS_W'(WPS - 1)) || last);

  always_comb begin
    pos_d = pos_q;
    wis_d = wis_q;
    if (load) begin
      pos_d = chs_in;
      wis_d = '0;
    end else if (adv) begin
      wis_d = '0;
      if (pos_q.sect >= SECT_W'(SPT - 1)) begin
        pos_d.sect = '0;
        if (pos_q.head) begin
          pos_d.head = 1'b0;
          pos_d.cyl  = pos_q.cyl + 1'b1;
        end else begin
          pos_d.head = 1'b1;
        end
      end else begin
        pos_d.sect = pos_q.sect + 1'b1;
      end
    end else if (step) begin
      wis_d = wis_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      wis_q <= '0;
    end else if (load || step) begin
      pos_q <= pos_d;
      wis_q <= wis_d;
    end
  end

  logic [OFF_W-1:0] trk;
  assign trk    = OFF_W'({pos_q.cyl, pos_q.head});
  assign offset = (trk * OFF_W'(SPT) + OFF_W'(pos_q.sect)) * OFF_W'(SECT_BYTES)
                  + OFF_W'({wis_q, 1'b0});
  assign pos    = pos_q;

  // R8: a sector at or past the last one wraps to zero
  a_r8_sect_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pos_q.sect >= SECT_W'(SPT - 1)) |=> (pos_q.sect == '0));
  // R4: inside a sector the offset moves by one word
  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adv && !load) |=> (offset == $past(offset) + OFF_W'(2)));
endmodule

// File: rtl/dskrd_addr.sv
module dskrd_addr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = base;
    else if (step) addr_d = addr_q + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (load || step) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R6: each granted word moves the address on by two, modulo the bus width
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q == $past(addr_q) + ADDR_W'(2)));
endmodule

// File: rtl/dskrd_cnt.sv
module dskrd_cnt #(
  parameter int CW_IN = 16,
  localparam int CNT_W = CW_IN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CW_IN-1:0] wcnt,
  input  logic             step,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = {1'b1, {CW_IN{1'b0}}} - {1'b0, wcnt};
    else if (step) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rem_q <= '0;
    else if (load || step) rem_q <= rem_d;
  end

  assign last = (rem_q == CNT_W'(1));

  // R5: every granted word uses up exactly one count
  a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/dskrd_seq.sv
module dskrd_seq
  import dskrd_pkg::*;
#(
  parameter int SPT        = 40,
  parameter int SECT_BYTES = 256,
  parameter int ADDR_W     = 18,
  localparam int OFF_W     = $clog2((2 ** CYL_W) * 2 * SPT * SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_func,
  input  logic [15:0]       dar,
  input  logic [15:0]       wcnt,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data,
  output logic [OFF_W-1:0]  img_addr,
  input  logic [15:0]       img_data,
  output logic [8:0]        pos_cyl,
  output logic              pos_head,
  output logic [5:0]        pos_sect
);
  logic busy_q, busy_d, done_q, done_d;
  logic start, step, last;
  chs_t chs_in, pos;

  assign start  = cmd_valid && !busy_q &&
                  ((cmd_func == FN_READ) || (cmd_func == FN_READNH));
  assign step   = busy_q && mem_gnt;
  assign chs_in = chs_t'(dar);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
    end else if (step && last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  dskrd_pos #(.SPT(SPT), .SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .load(start), .chs_in(chs_in),
    .step(step), .last(last), .pos(pos), .offset(img_addr)
  );

  dskrd_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .base(base_addr),
    .step(step), .addr(mem_addr)
  );

  dskrd_cnt #(.CW_IN(16)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start), .wcnt(wcnt),
    .step(step), .last(last)
  );

  assign busy     = busy_q;
  assign done     = done_q;
  assign mem_req  = busy_q;
  assign mem_data = img_data;
  assign pos_cyl  = pos.cyl;
  assign pos_head = pos.head;
  assign pos_sect = pos.sect;

  // R9: the completion pulse comes with busy already low and lasts one cycle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: a stalled request keeps its addresses
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_gnt) |=> ($stable(mem_addr) && $stable(img_addr)));
  // R10: a command during a transfer leaves the address untouched
  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid && !mem_gnt) |=> $stable(mem_addr));
endmodule

// File: tb/dskrd_seq_test.sv
`timescale 1ns/1ps
module dskrd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_func = '0;
  logic [15:0] dar = '0, wcnt = '0;
  logic [17:0] base_addr = '0;
  logic        busy, done, mem_req, mem_gnt;
  logic [17:0] mem_addr;
  logic [15:0] mem_data, img_data;
  logic [23:0] img_addr;
  logic [8:0]  pos_cyl;
  logic        pos_head;
  logic [5:0]  pos_sect;

  always #2.5 clk = ~clk;

  dskrd_seq uut (.*);

  function automatic logic [15:0] img_fn(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h5A3C;
  endfunction
  assign img_data = img_fn(img_addr);

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_busy = 0, m_done = 0, m_addr = 0, m_rem = 0, m_grants = 0;
  int m_cyl = 0, m_head = 0, m_sect = 0, m_wis = 0;
  int gmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic gnt_r = 1'b0;
  assign mem_gnt = gnt_r;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (m_busy != 0) begin
        if (gnt_r) begin
          m_grants++;
          m_addr = (m_addr + 2) % 262144;
          if (m_wis == 127 || m_rem == 1) begin
            m_wis = 0;
            if (m_sect + 1 >= 40) begin
              m_sect = 0;
              if (m_head == 1) begin m_head = 0; m_cyl = (m_cyl + 1) % 512; end
              else m_head = 1;
            end else m_sect++;
          end else m_wis++;
          m_rem--;
          if (m_rem == 0) begin m_busy = 0; m_done = 1; end
        end
      end else if (cmd_valid && (cmd_func == 3'd6 || cmd_func == 3'd7)) begin
        m_busy = 1; m_grants = 0;
        m_rem = 65536 - int'(wcnt);
        m_addr = int'(base_addr);
        m_sect = int'(dar[5:0]); m_head = int'(dar[6]); m_cyl = int'(dar[15:7]);
        m_wis = 0;
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gnt_r <= (gmode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  function automatic int exp_off();
    return ((m_cyl * 2 + m_head) * 40 + m_sect) * 256 + 2 * m_wis;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_busy != 0), "R9 busy", int'(busy), m_busy);
      chk(done == (m_done != 0), "R9 done", int'(done), m_done);
      chk(mem_req == (m_busy != 0), "R7 mem_req", int'(mem_req), m_busy);
      chk(int'(mem_addr) == m_addr, "R6 mem_addr", int'(mem_addr), m_addr);
      chk(int'(img_addr) == exp_off(), "R4 img_addr", int'(img_addr), exp_off());
      chk(int'(pos_cyl) == m_cyl && int'(pos_head) == m_head && int'(pos_sect) == m_sect,
          "R8 position", int'({pos_cyl, pos_head, pos_sect}), (m_cyl * 2 + m_head) * 64 + m_sect);
      if (m_busy != 0)
        chk(mem_data == img_fn(24'(exp_off())), "R7 mem_data", int'(mem_data),
            int'(img_fn(24'(exp_off()))));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] f, input logic [15:0] d, input logic [15:0] w,
                       input logic [17:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; dar = d; wcnt = w; base_addr = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_xfer(input logic [2:0] f, input int cyl, input int hd, input int sc,
                          input int words, input logic [17:0] b, input int mode,
                          input bit inject);
    logic [15:0] d;
    d = {7'(cyl), 1'(hd), 6'(sc)} ;
    d = {cyl[8:0], hd[0], sc[5:0]};
    gmode = mode;
    issue(f, d, 16'(65536 - words), b);
    chk(int'(pos_cyl) == cyl && int'(pos_head) == hd && int'(pos_sect) == sc,
        "R3 decode", int'({pos_cyl, pos_head, pos_sect}), int'(d));
    if (inject) begin
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1; cmd_func = 3'd6; dar = 16'h1234; wcnt = 16'hFFF0; base_addr = 18'h00100;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(int'(pos_cyl) == m_cyl && int'(mem_addr) == m_addr && busy,
          "R10 ignored command", int'(mem_addr), m_addr);
    end
    while (m_done == 0) @(negedge clk);
    chk(m_grants == words, "R5 word count", m_grants, words);
    chk(done && int'(mem_addr) == (int'(b) + 2 * words) % 262144, "R9 final address",
        int'(mem_addr), (int'(b) + 2 * words) % 262144);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && mem_addr == '0 && img_addr == '0 &&
        pos_cyl == '0 && !pos_head && pos_sect == '0, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: non-read code does nothing
    issue(3'd3, 16'h0042, 16'hFFF0, 18'h01000);
    chk(!busy && !mem_req, "R2 other code ignored", int'(busy), 0);
    issue(3'd2, 16'h0042, 16'hFFF0, 18'h01000);
    chk(!busy && mem_addr == '0, "R2 status code ignored", int'(mem_addr), 0);
    // R8 head rollover, R6 carry into bit 16
    run_xfer(3'd6, 5, 0, 38, 300, 18'h0FFF0, 0, 1'b0);
    // R8 cylinder wrap, R6 18-bit wrap, R10 mid-transfer command, stalls
    run_xfer(3'd7, 511, 1, 39, 130, 18'h3FFFC, 1, 1'b1);
    // single word, out-of-range sector
    run_xfer(3'd6, 100, 0, 45, 1, 18'h00200, 1, 1'b0);
    chk(pos_sect == 6'd0 && pos_head, "R8 sector past end wraps", int'(pos_sect), 0);
    // full 65536-word transfer from a zero count
    run_xfer(3'd6, 2, 1, 0, 65536, 18'h00000, 0, 1'b0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule